// File: doc/BRIEF.md
# EEPROM Access and Burst Load Engine

This block connects a host register window to a byte-wide EEPROM port that uses a request/acknowledge handshake. Software can fetch one byte from a programmed EEPROM address into a data register. It can store the low byte of that data register into the EEPROM. It can also start a burst that copies EEPROM-resident records into a 24-bit on-chip memory space through a single-cycle write strobe.

Request bits clear themselves when their operation completes, so software starts an operation and then polls its bit. A burst interprets the EEPROM stream as three-byte records: address high, address low, data. Each data byte goes to a memory address. The upper nine bits of that address come from a base register and the lower fifteen bits come from the record, with the record's top address bit discarded. A record whose two address bytes are both 0xFF ends the burst.

The EEPROM position at which a burst begins is tracked across operations. A burst that starts before any access since reset begins at byte 0. Any other burst resumes just past the last byte touched, whether a single read or write touched it or an earlier burst did.

Top module: `eeprom_loader`

## Requirements
- R1: After reset every register reads 0, `ee_req` is low and no memory write strobe occurs.
- R2: Writing bit 1 of the control register starts a read of the EEPROM byte at the address register. Bit 1 reads back as 1 while the read is in progress and clears in the same cycle that the fetched byte appears in data register bits [7:0].
- R3: Writing bit 0 of the control register stores data register bits [7:0] at the address register's EEPROM location. Bit 0 then clears by itself.
- R4: Host register offsets and fields are as follows:
  - control at 0x2000, with bit 0 the write request and bit 1 the read request;
  - data at 0x2004, in bits [7:0];
  - address at 0x2008, in bits [15:0];
  - burst start at 0x200C, in bit 0;
  - memory base at 0x2010, in bits [8:0].
  Unmapped offsets read 0.
- R5: A burst with no EEPROM access since reset starts at EEPROM byte 0. Any later burst starts one past the last EEPROM byte accessed, including a terminator byte read by an earlier burst.
- R6: A burst reads records of three bytes (high address byte AH, low address byte AL, data D). Each record gives one single-cycle `mem_we` pulse with `mem_addr` = {base[8:0], AH[6:0], AL} and `mem_wdata` = D. AH bit 7 is ignored.
- R7: A record with AH = AL = 0xFF ends the burst without a memory write, and clears burst-start bit 0. A record address of 0x7FFF is not a terminator.
- R8: `ee_req` stays high with `ee_addr` and `ee_we` stable until `ee_ack` is sampled. It drops the following cycle, so at most one transaction is outstanding.
- R9: While a single access or a burst is in progress, writes to the control or burst-start register are ignored.
- R10: A control write that sets bits 0 and 1 together performs only the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 14 | Host register byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Register read data for `host_addr` (combinational) |
| ee_req | output | 1 | EEPROM transaction request |
| ee_we | output | 1 | EEPROM transaction is a write |
| ee_addr | output | 16 | EEPROM byte address |
| ee_wdata | output | 8 | EEPROM write byte |
| ee_ack | input | 1 | EEPROM transaction complete (one-cycle pulse) |
| ee_rdata | input | 8 | EEPROM read byte, valid with `ee_ack` |
| mem_we | output | 1 | Memory write strobe, one cycle |
| mem_addr | output | 24 | Memory write address |
| mem_wdata | output | 8 | Memory write byte |

## Verification
The checks assume that the EEPROM side raises `ee_ack` for one cycle, only while `ee_req` is high, and returns `ee_rdata` in that cycle. The bench's byte-array model does exactly this, with a latency that changes between scenarios. The checks also assume that every burst stream ends in a terminator. The bench therefore places a terminator after every set of records it loads, and never leaves a burst to run through unwritten array contents.

// File: rtl/eeprom_loader_pkg.sv
package eeprom_loader_pkg;

    localparam int HOST_AW = 14;
    localparam int BASE_W  = 9;
    localparam int LOW_W   = 15;
    localparam int MEM_AW  = BASE_W + LOW_W;

    localparam logic [HOST_AW-1:0] OFS_CTL   = 14'h2000;
    localparam logic [HOST_AW-1:0] OFS_DATA  = 14'h2004;
    localparam logic [HOST_AW-1:0] OFS_ADDR  = 14'h2008;
    localparam logic [HOST_AW-1:0] OFS_BURST = 14'h200C;
    localparam logic [HOST_AW-1:0] OFS_BASE  = 14'h2010;

    localparam logic [15:0] REC_END = 16'hFFFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SINGLE,
        ST_AHI,
        ST_ALO,
        ST_DAT
    } seq_state_e;

    function automatic logic [MEM_AW-1:0] make_mem_addr(
        input logic [BASE_W-1:0] base,
        input logic [6:0]        hi7,
        input logic [7:0]        lo8
    );
        return {base, hi7, lo8};
    endfunction

endpackage

// File: rtl/eeprom_loader_regs.sv
module eeprom_loader_regs
    import eeprom_loader_pkg::*;
#(
    parameter int EE_AW = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    input  logic               done_single,
    input  logic               done_burst,
    input  logic               rd_valid,
    input  logic [7:0]         rd_byte,
    output logic               ctl_rd,
    output logic               ctl_wr,
    output logic               burst_on,
    output logic [7:0]         data_q,
    output logic [EE_AW-1:0]   addr_q,
    output logic [BASE_W-1:0]  base_q
);

    logic any_busy;
    logic unused_wdata;

    assign any_busy     = ctl_rd | ctl_wr | burst_on;
    assign unused_wdata = ^host_wdata[31:EE_AW];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_rd   <= 1'b0;
            ctl_wr   <= 1'b0;
            burst_on <= 1'b0;
            data_q   <= '0;
            addr_q   <= '0;
            base_q   <= '0;
        end else begin
            if (host_wr && !any_busy && host_addr == OFS_CTL) begin
                ctl_rd <= host_wdata[1];
                ctl_wr <= host_wdata[0] & ~host_wdata[1];
            end else if (done_single) begin
                ctl_rd <= 1'b0;
                ctl_wr <= 1'b0;
            end

            if (host_wr && !any_busy && host_addr == OFS_BURST)
                burst_on <= host_wdata[0];
            else if (done_burst)
                burst_on <= 1'b0;

            if (rd_valid)
                data_q <= rd_byte;
            else if (host_wr && host_addr == OFS_DATA)
                data_q <= host_wdata[7:0];

            if (host_wr && host_addr == OFS_ADDR)
                addr_q <= host_wdata[EE_AW-1:0];

            if (host_wr && host_addr == OFS_BASE)
                base_q <= host_wdata[BASE_W-1:0];
        end
    end

    always_comb begin
        case (host_addr)
            OFS_CTL:   host_rdata = {30'b0, ctl_rd, ctl_wr};
            OFS_DATA:  host_rdata = {24'b0, data_q};
            OFS_ADDR:  host_rdata = 32'(addr_q);
            OFS_BURST: host_rdata = {31'b0, burst_on};
            OFS_BASE:  host_rdata = 32'(base_q);
            default:   host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/eeprom_loader_seq.sv
module eeprom_loader_seq
    import eeprom_loader_pkg::*;
#(
    parameter int EE_AW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go_rd,
    input  logic              go_wr,
    input  logic              go_burst,
    input  logic [EE_AW-1:0]  addr_q,
    input  logic [7:0]        data_q,
    input  logic [BASE_W-1:0] base_q,
    output logic              ee_req,
    output logic              ee_we,
    output logic [EE_AW-1:0]  ee_addr,
    output logic [7:0]        ee_wdata,
    input  logic              ee_ack,
    input  logic [7:0]        ee_rdata,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              done_single,
    output logic              done_burst,
    output logic              rd_valid
);

    localparam logic [EE_AW-1:0] ONE = 1;

    seq_state_e       state;
    logic [EE_AW-1:0] nxt_addr;
    logic [7:0]       rec_hi;
    logic [7:0]       rec_lo;
    logic             hit;

    assign hit         = ee_req && ee_ack;
    assign done_single = (state == ST_SINGLE) && hit;
    assign rd_valid    = done_single && !ee_we;
    assign done_burst  = (state == ST_ALO) && hit && ({rec_hi, ee_rdata} == REC_END);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            ee_req    <= 1'b0;
            ee_we     <= 1'b0;
            ee_addr   <= '0;
            ee_wdata  <= '0;
            nxt_addr  <= '0;
            rec_hi    <= '0;
            rec_lo    <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= 1'b0;
            if (state != ST_IDLE)
                ee_req <= !hit;

            case (state)
                ST_IDLE: begin
                    if (go_rd || go_wr) begin
                        ee_addr  <= addr_q;
                        ee_we    <= go_wr & ~go_rd;
                        ee_wdata <= data_q;
                        state    <= ST_SINGLE;
                    end else if (go_burst) begin
                        ee_addr <= nxt_addr;
                        ee_we   <= 1'b0;
                        state   <= ST_AHI;
                    end
                end
                ST_SINGLE: begin
                    if (hit) begin
                        nxt_addr <= ee_addr + ONE;
                        ee_we    <= 1'b0;
                        state    <= ST_IDLE;
                    end
                end
                ST_AHI: begin
                    if (hit) begin
                        rec_hi   <= ee_rdata;
                        ee_addr  <= ee_addr + ONE;
                        nxt_addr <= ee_addr + ONE;
                        state    <= ST_ALO;
                    end
                end
                ST_ALO: begin
                    if (hit) begin
                        rec_lo   <= ee_rdata;
                        ee_addr  <= ee_addr + ONE;
                        nxt_addr <= ee_addr + ONE;
                        state    <= ({rec_hi, ee_rdata} == REC_END) ? ST_IDLE : ST_DAT;
                    end
                end
                ST_DAT: begin
                    if (hit) begin
                        mem_we    <= 1'b1;
                        mem_addr  <= make_mem_addr(base_q, rec_hi[6:0], rec_lo);
                        mem_wdata <= ee_rdata;
                        ee_addr   <= ee_addr + ONE;
                        nxt_addr  <= ee_addr + ONE;
                        state     <= ST_AHI;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/eeprom_loader.sv
module eeprom_loader
    import eeprom_loader_pkg::*;
#(
    parameter int EE_AW = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    output logic               ee_req,
    output logic               ee_we,
    output logic [EE_AW-1:0]   ee_addr,
    output logic [7:0]         ee_wdata,
    input  logic               ee_ack,
    input  logic [7:0]         ee_rdata,
    output logic               mem_we,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic [7:0]         mem_wdata
);

    logic              ctl_rd;
    logic              ctl_wr;
    logic              burst_on;
    logic [7:0]        data_q;
    logic [EE_AW-1:0]  addr_q;
    logic [BASE_W-1:0] base_q;
    logic              done_single;
    logic              done_burst;
    logic              rd_valid;

    eeprom_loader_regs #(.EE_AW(EE_AW)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .host_wr     (host_wr),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .done_single (done_single),
        .done_burst  (done_burst),
        .rd_valid    (rd_valid),
        .rd_byte     (ee_rdata),
        .ctl_rd      (ctl_rd),
        .ctl_wr      (ctl_wr),
        .burst_on    (burst_on),
        .data_q      (data_q),
        .addr_q      (addr_q),
        .base_q      (base_q)
    );

    eeprom_loader_seq #(.EE_AW(EE_AW)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .go_rd       (ctl_rd),
        .go_wr       (ctl_wr),
        .go_burst    (burst_on),
        .addr_q      (addr_q),
        .data_q      (data_q),
        .base_q      (base_q),
        .ee_req      (ee_req),
        .ee_we       (ee_we),
        .ee_addr     (ee_addr),
        .ee_wdata    (ee_wdata),
        .ee_ack      (ee_ack),
        .ee_rdata    (ee_rdata),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .done_single (done_single),
        .done_burst  (done_burst),
        .rd_valid    (rd_valid)
    );

endmodule

// File: rtl/eeprom_loader_chk.sv
module eeprom_loader_chk #(
    parameter int EE_AW = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             ee_req,
    input logic             ee_ack,
    input logic             ee_we,
    input logic [EE_AW-1:0] ee_addr,
    input logic             mem_we,
    input logic             ctl_rd,
    input logic             ctl_wr,
    input logic             burst_on
);

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
        ee_req && !ee_ack |=> ee_req && $stable(ee_addr) && $stable(ee_we));

    assert_req_drop_R8: assert property (@(posedge clk) disable iff (rst)
        ee_req && ee_ack |=> !ee_req);

    assert_mem_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    assert_mem_in_burst_R6: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> burst_on);

    assert_one_op_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl_rd, ctl_wr, burst_on}));

    assert_we_single_R3: assert property (@(posedge clk) disable iff (rst)
        ee_req && ee_we |-> ctl_wr);

    assert_rd_clear_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl_rd) |-> $past(ee_ack));

endmodule

bind eeprom_loader eeprom_loader_chk #(.EE_AW(EE_AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ee_req   (ee_req),
    .ee_ack   (ee_ack),
    .ee_we    (ee_we),
    .ee_addr  (ee_addr),
    .mem_we   (mem_we),
    .ctl_rd   (ctl_rd),
    .ctl_wr   (ctl_wr),
    .burst_on (burst_on)
);

// File: tb/tb_eeprom_loader.sv
module tb_eeprom_loader;
    import eeprom_loader_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [13:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        ee_req, ee_we;
    logic [15:0] ee_addr;
    logic [7:0]  ee_wdata;
    logic        ee_ack = 1'b0;
    logic [7:0]  ee_rdata = '0;
    logic        mem_we;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata;

    always #4 clk = ~clk;

    eeprom_loader dut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata),
        .ee_ack(ee_ack), .ee_rdata(ee_rdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    logic [7:0]  rom [0:4095];
    int          lat = 2;
    int          wcnt = 0;
    int          acks = 0;
    int          viol = 0;
    logic [15:0] held_addr = '0;
    logic [23:0] wr_addr [0:15];
    logic [7:0]  wr_data [0:15];
    int          nwr = 0;
    int          checks = 0;
    int          failures = 0;

    function automatic logic [7:0] pat(input int i);
        return 8'(i * 7 + 3);
    endfunction

    // behavioural EEPROM: acts at falling edges
    initial begin
        for (int i = 0; i < 4096; i++) rom[i] = pat(i);
        forever begin
            @(negedge clk);
            if (ee_ack) begin
                ee_ack = 1'b0;
                wcnt = 0;
                if (ee_req) viol++;
            end else if (ee_req) begin
                if (wcnt > 0 && ee_addr != held_addr) viol++;
                held_addr = ee_addr;
                wcnt++;
                if (wcnt >= lat) begin
                    ee_ack = 1'b1;
                    acks++;
                    if (ee_we) rom[ee_addr[11:0]] = ee_wdata;
                    else ee_rdata = rom[ee_addr[11:0]];
                end
            end else if (wcnt > 0) begin
                viol++;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (mem_we && nwr < 16) begin
                wr_addr[nwr] = mem_addr;
                wr_data[nwr] = mem_wdata;
                nwr++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish (actual timeout, expected completion)");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hwrite(input logic [13:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [13:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic wait_clear(input logic [13:0] a, input logic [31:0] mask, input string tag);
        logic [31:0] v;
        int n = 0;
        hread(a, v);
        while ((v & mask) != 0 && n < 2000) begin
            hread(a, v);
            n++;
        end
        check((v & mask) == 0, tag, v, v & ~mask);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        hread(OFS_CTL, v);   check(v == 0, "R1 ctl reset", v, 0);
        hread(OFS_DATA, v);  check(v == 0, "R1 data reset", v, 0);
        hread(OFS_ADDR, v);  check(v == 0, "R1 addr reset", v, 0);
        hread(OFS_BURST, v); check(v == 0, "R1 burst reset", v, 0);
        hread(OFS_BASE, v);  check(v == 0, "R1 base reset", v, 0);
        check(ee_req == 1'b0 && nwr == 0, "R1 idle outputs", {ee_req, 8'(nwr)}, 0);
    endtask

    task automatic t_burst_fresh();
        logic [31:0] v;
        lat = 1;
        rom[0] = 8'h81; rom[1] = 8'h23; rom[2] = 8'h5A;
        rom[3] = 8'h00; rom[4] = 8'h07; rom[5] = 8'hC3;
        rom[6] = 8'hFF; rom[7] = 8'hFF;
        hwrite(OFS_BASE, 32'h1AB);
        hread(OFS_BASE, v); check(v == 32'h1AB, "R4 base field", v, 32'h1AB);
        hwrite(OFS_BURST, 1);
        hread(OFS_BURST, v); check(v == 1, "R4 burst busy", v, 1);
        wait_clear(OFS_BURST, 1, "R7 burst self-clear");
        check(nwr == 2, "R5 fresh burst write count", nwr, 2);
        check(wr_addr[0] == {9'h1AB, 7'h01, 8'h23}, "R6 addr with AH bit7 ignored",
              wr_addr[0], {9'h1AB, 7'h01, 8'h23});
        check(wr_data[0] == 8'h5A, "R6 data 0", wr_data[0], 8'h5A);
        check(wr_addr[1] == {9'h1AB, 7'h00, 8'h07} && wr_data[1] == 8'hC3, "R6 record 1",
              {wr_data[1], wr_addr[1]}, {8'hC3, 9'h1AB, 7'h00, 8'h07});
    endtask

    task automatic t_read();
        logic [31:0] v;
        lat = 3;
        hwrite(OFS_ADDR, 32'h10);
        hwrite(OFS_CTL, 2);
        hread(OFS_CTL, v); check(v == 2, "R2 read bit busy", v, 2);
        wait_clear(OFS_CTL, 2, "R2 read self-clear");
        hread(OFS_DATA, v); check(v == 32'(pat(16'h10)), "R2 read data", v, 32'(pat(16'h10)));
    endtask

    task automatic t_write();
        logic [31:0] v;
        lat = 2;
        hwrite(OFS_ADDR, 32'h20);
        hwrite(OFS_DATA, 32'h3C5);
        hread(OFS_DATA, v); check(v == 32'hC5, "R4 data field low byte", v, 32'hC5);
        hwrite(OFS_CTL, 1);
        wait_clear(OFS_CTL, 1, "R3 write self-clear");
        check(rom[12'h20] == 8'hC5, "R3 byte stored", rom[12'h20], 8'hC5);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        int a0, w0;
        lat = 6;
        hwrite(OFS_ADDR, 32'h30);
        hwrite(OFS_DATA, 32'h77);
        a0 = acks; w0 = nwr;
        hwrite(OFS_CTL, 2);
        hwrite(OFS_CTL, 1);
        hwrite(OFS_BURST, 1);
        hread(OFS_BURST, v); check(v == 0, "R9 burst start ignored", v, 0);
        hread(OFS_CTL, v); check(v == 2, "R9 ctl unchanged while busy", v, 2);
        wait_clear(OFS_CTL, 3, "R9 op completes");
        repeat (20) @(negedge clk);
        check(acks - a0 == 1, "R9 single transaction", acks - a0, 1);
        check(rom[12'h30] == pat(16'h30), "R9 no write performed", rom[12'h30], pat(16'h30));
        check(nwr == w0, "R9 no memory writes", nwr, w0);
    endtask

    task automatic t_both();
        logic [31:0] v;
        int a0;
        lat = 2;
        hwrite(OFS_ADDR, 32'h40);
        hwrite(OFS_DATA, 32'h99);
        a0 = acks;
        hwrite(OFS_CTL, 3);
        wait_clear(OFS_CTL, 3, "R10 completes");
        hread(OFS_DATA, v); check(v == 32'(pat(16'h40)), "R10 read done", v, 32'(pat(16'h40)));
        check(rom[12'h40] == pat(16'h40) && acks - a0 == 1, "R10 no write",
              rom[12'h40], pat(16'h40));
    endtask

    task automatic t_burst_after_access();
        logic [31:0] v;
        int w0;
        lat = 1;
        hwrite(OFS_ADDR, 32'h200);
        hwrite(OFS_DATA, 32'h12);
        hwrite(OFS_CTL, 1);
        wait_clear(OFS_CTL, 1, "R3 write at 0x200");
        rom[12'h201] = 8'h7F; rom[12'h202] = 8'hFF; rom[12'h203] = 8'h11;
        rom[12'h204] = 8'hFF; rom[12'h205] = 8'hFF;
        hwrite(OFS_BASE, 32'h005);
        w0 = nwr;
        hwrite(OFS_BURST, 1);
        wait_clear(OFS_BURST, 1, "R5 burst done");
        check(nwr == w0 + 1, "R7 0x7FFF is not terminator", nwr, w0 + 1);
        check(wr_addr[w0] == 24'h02FFFF && wr_data[w0] == 8'h11, "R5 resumed after access",
              {wr_data[w0], wr_addr[w0]}, {8'h11, 24'h02FFFF});
    endtask

    task automatic t_burst_continue();
        int a0, w0;
        lat = 2;
        rom[12'h206] = 8'hFF; rom[12'h207] = 8'hFF;
        a0 = acks; w0 = nwr;
        hwrite(OFS_BURST, 1);
        wait_clear(OFS_BURST, 1, "R7 terminator only");
        check(nwr == w0, "R7 no write on terminator", nwr, w0);
        check(acks - a0 == 2, "R5 resumes after previous terminator", acks - a0, 2);
        check(viol == 0, "R8 handshake violations", viol, 0);
    endtask

    initial begin
        t_reset();
        t_burst_fresh();
        t_read();
        t_write();
        t_busy_ignore();
        t_both();
        t_burst_after_access();
        t_burst_continue();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule